// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers interrupt requests from fifteen maskable sources, holds each in a sticky pending flag, and raises one request line toward the CPU. When that line is high, the block also presents the program-memory address that the fetch unit should branch to. A single CPU-wide enable gates the request. Each source also has its own enable. The watchdog source is the one exception: it has no mask bit and is qualified by the watchdog-on input. Software reads and writes the pending flags and the enable masks through a small byte-wide register port. It issues enable and disable strobes, and it acknowledges a taken interrupt.

Source ranks run from 0 (highest priority) to 14 (lowest). The vector of rank r is three times a slot number. The slot number is r+1, plus one for each gap that lies at or below the rank. Gaps sit before ranks 3, 8 and 12, so three-word slots 0x000C, 0x001E and 0x002D are skipped. Address 0x0000 belongs to reset. The block reports 0x0000 whenever nothing is requested.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A one-cycle high on `src_pulse[i]` sets pending flag i at the next clock edge, and the flag stays set. If a software write of 0 to that flag lands in the same cycle as the pulse, the flag still ends up set.
- R2: Flags are only changed by pulses and software writes. An acknowledge leaves every flag as it was, so an uncleared flag requests again once the CPU-wide enable returns.
- R3: Rank 0 is eligible when its flag and `wdt_on` are both high. Rank i (1 to 14) is eligible when its flag and enable bit i-1 are both high. `cpu_req` is high exactly when the CPU-wide enable is set and at least one rank is eligible.
- R4: `gie_set` sets the CPU-wide enable and `gie_clr` clears it, with the clear winning if both arrive in the same cycle. A taken acknowledge (`ack` while `cpu_req` is high) also clears it. Each change shows at the next edge.
- R5: While `cpu_req` is high, `vector` gives the address of the lowest-numbered eligible rank. In rank order the addresses are 0x0003, 0x0006, 0x0009, 0x000F, 0x0012, 0x0015, 0x0018, 0x001B, 0x0021, 0x0024, 0x0027, 0x002A, 0x0030, 0x0033 and 0x0036.
- R6: While `cpu_req` is low, `vector` is 0x0000.
- R7: `vector` never takes the values 0x000C, 0x001E or 0x002D.
- R8: On a taken acknowledge, `vec_taken` loads the current `vector` at the next edge. Otherwise it holds its value.
- R9: Register port addresses are as follows. Address 0 holds flags 7..0 in bits 7..0. Address 1 holds flags 11..8 in bits 3..0. Address 2 holds flags 14..12 in bits 2..0. Address 3 holds enable bits 7..0. Address 4 holds enable bits 13..8 in bits 5..0. Unused bits and addresses 5 to 7 read as 0. A write with `reg_wr` high replaces the implemented bits at the next edge, and `reg_rdata` reflects the addressed register without delay.
- R10: Synchronous reset clears all flags, all enables, the CPU-wide enable and `vec_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_pulse | input | 15 | Request pulses, bit = rank |
| wdt_on | input | 1 | Qualifier for the rank-0 watchdog source |
| gie_set | input | 1 | Set the CPU-wide enable |
| gie_clr | input | 1 | Clear the CPU-wide enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ack | input | 1 | CPU acknowledge of the request |
| cpu_req | output | 1 | Interrupt request to the CPU |
| vector | output | 16 | Vector of the winning source, else 0 |
| vec_taken | output | 16 | Vector captured on the last taken acknowledge |

## Verification
Several properties are checked on every cycle:
- pending flags never fall without a status write, and a pulse always leaves its flag set;
- the thermometer-masked grant is one-hot and agrees with the separately built rank encoder;
- the vector avoids the three gap addresses and is zero when idle;
- an acknowledge both captures the vector and drops the request.

Some behaviour can only be shown by the bench's scenarios:
- the exact address returned for each rank;
- the masking of a higher-rank flag by its enable or by `wdt_on`;
- the register bit layout with its zero-reading unused bits;
- retaking an uncleared flag after the enable is restored.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int NSRC   = 15;
    localparam int NEN    = NSRC - 1;
    localparam int RANK_W = $clog2(NSRC);
    localparam int VEC_W  = 16;
    localparam int DW     = 8;
    localparam int AW     = 3;

    // register layout split
    localparam int ST0_N  = 8;
    localparam int ST1_N  = 4;
    localparam int ST2_N  = NSRC - ST0_N - ST1_N;
    localparam int ST1_LO = ST0_N;
    localparam int ST2_LO = ST0_N + ST1_N;
    localparam int MK0_N  = 8;
    localparam int MK1_N  = NEN - MK0_N;

    // ranks in front of which one vector slot is skipped
    localparam int GAP_A = 3;
    localparam int GAP_B = 8;
    localparam int GAP_C = 12;
    localparam int SLOT_WORDS = 3;

    typedef enum logic [AW-1:0] {
        RA_ST0 = 3'd0,
        RA_ST1 = 3'd1,
        RA_ST2 = 3'd2,
        RA_MK0 = 3'd3,
        RA_MK1 = 3'd4
    } reg_sel_e;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        logic              valid;
        logic [RANK_W-1:0] rank;
    } pick_t;

    function automatic logic [VEC_W-1:0] rank_to_vec(input logic [RANK_W-1:0] r);
        int rk;
        int slot;
        rk   = int'(r);
        slot = rk + 1;
        if (rk >= GAP_A) slot++;
        if (rk >= GAP_B) slot++;
        if (rk >= GAP_C) slot++;
        return VEC_W'(SLOT_WORDS * slot);
    endfunction

endpackage

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  src_vec_t          pulse,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output src_vec_t          flags,
    output logic [NEN-1:0]    enables,
    output logic [DW-1:0]     rdata
);

    src_vec_t          flag_wr;
    logic [NEN-1:0]    en_nxt;
    logic              st_wr;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(reg_addr);

    always_comb begin
        flag_wr = flags;
        en_nxt  = enables;
        st_wr   = 1'b0;
        if (reg_wr) begin
            case (sel)
                RA_ST0: begin flag_wr[ST0_N-1:0]         = reg_wdata[ST0_N-1:0]; st_wr = 1'b1; end
                RA_ST1: begin flag_wr[ST1_LO +: ST1_N]   = reg_wdata[ST1_N-1:0]; st_wr = 1'b1; end
                RA_ST2: begin flag_wr[ST2_LO +: ST2_N]   = reg_wdata[ST2_N-1:0]; st_wr = 1'b1; end
                RA_MK0: en_nxt[MK0_N-1:0]                = reg_wdata[MK0_N-1:0];
                RA_MK1: en_nxt[MK0_N +: MK1_N]           = reg_wdata[MK1_N-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            enables <= '0;
        end else begin
            flags   <= flag_wr | pulse;   // set beats clear
            enables <= en_nxt;
        end
    end

    always_comb begin
        case (sel)
            RA_ST0:  rdata = DW'(flags[ST0_N-1:0]);
            RA_ST1:  rdata = DW'(flags[ST1_LO +: ST1_N]);
            RA_ST2:  rdata = DW'(flags[ST2_LO +: ST2_N]);
            RA_MK0:  rdata = DW'(enables[MK0_N-1:0]);
            RA_MK1:  rdata = DW'(enables[MK0_N +: MK1_N]);
            default: rdata = '0;
        endcase
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !st_wr |=> (($past(flags) & ~flags) == '0)); // R2

    AST_PULSE_SETS: assert property (@(posedge clk) disable iff (rst)
        (|pulse) |=> ((flags & $past(pulse)) == $past(pulse))); // R1

endmodule

// File: rtl/irqv_prio_sel.sv
module irqv_prio_sel
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  src_vec_t          active,
    output pick_t             pick,
    output logic [VEC_W-1:0]  win_vec
);

    src_vec_t grant;

    // thermometer-style grant, one term per rank
    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_grant
            if (g == 0) begin : g_top
                assign grant[g] = active[g];
            end else begin : g_rest
                assign grant[g] = active[g] & ~(|active[g-1:0]);
            end
        end
    endgenerate

    // rank encoder built independently of the grant vector
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (active[i]) begin
                pick.valid = 1'b1;
                pick.rank  = RANK_W'(i);
            end
        end
    end

    assign win_vec = pick.valid ? rank_to_vec(pick.rank) : '0;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R5

    AST_GRANT_MATCH: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> grant[pick.rank]); // R5

    AST_NO_GAP_VEC: assert property (@(posedge clk) disable iff (rst)
        (win_vec != 16'h000C) && (win_vec != 16'h001E) && (win_vec != 16'h002D)); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (active == '0) |-> (win_vec == '0)); // R6

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [14:0]       src_pulse,
    input  logic              wdt_on,
    input  logic              gie_set,
    input  logic              gie_clr,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ack,
    output logic              cpu_req,
    output logic [15:0]       vector,
    output logic [15:0]       vec_taken
);

    src_vec_t          flags;
    logic [NEN-1:0]    enables;
    src_vec_t          active;
    pick_t             pick;
    logic [VEC_W-1:0]  win_vec;
    logic              gie_q;
    logic              taken;

    irqv_flag_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .pulse     (src_pulse),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flags     (flags),
        .enables   (enables),
        .rdata     (reg_rdata)
    );

    // rank 0 is qualified by the watchdog-on input, the rest by mask bits
    assign active = flags & {enables, wdt_on};

    irqv_prio_sel u_sel (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .pick    (pick),
        .win_vec (win_vec)
    );

    assign cpu_req = gie_q & pick.valid;
    assign vector  = cpu_req ? win_vec : '0;
    assign taken   = ack & cpu_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q     <= 1'b0;
            vec_taken <= '0;
        end else begin
            if (taken || gie_clr) gie_q <= 1'b0;
            else if (gie_set)     gie_q <= 1'b1;
            if (taken) vec_taken <= vector;
        end
    end

    AST_ACK_LATCH: assert property (@(posedge clk) disable iff (rst)
        taken |=> (vec_taken == $past(vector))); // R8

    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        taken |=> !cpu_req); // R4

    AST_CLR_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        gie_clr |=> !cpu_req); // R4

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !taken |=> $stable(vec_taken)); // R8

endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 11;

    // {pulses[14:0], enables[13:0], wdt_on, expected vector[15:0]}
    localparam logic [45:0] TBL [N_VEC] = '{
        {15'h0001, 14'h3FFF, 1'b1, 16'h0003},
        {15'h0001, 14'h3FFF, 1'b0, 16'h0000},
        {15'h7FFF, 14'h3FFF, 1'b0, 16'h0006},
        {15'h0034, 14'h3FFF, 1'b0, 16'h0009},
        {15'h4008, 14'h3FFF, 1'b1, 16'h000F},
        {15'h0300, 14'h3F7F, 1'b0, 16'h0024},
        {15'h0600, 14'h3FFF, 1'b0, 16'h0024},
        {15'h1000, 14'h3FFF, 1'b0, 16'h0030},
        {15'h4000, 14'h3FFF, 1'b0, 16'h0036},
        {15'h0800, 14'h0000, 1'b1, 16'h0000},
        {15'h0080, 14'h3FFF, 1'b0, 16'h001B}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [14:0] src_pulse;
    logic        wdt_on;
    logic        gie_set;
    logic        gie_clr;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        ack;
    logic        cpu_req;
    logic [15:0] vector;
    logic [15:0] vec_taken;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk       (clk),
        .rst       (rst),
        .src_pulse (src_pulse),
        .wdt_on    (wdt_on),
        .gie_set   (gie_set),
        .gie_clr   (gie_clr),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ack       (ack),
        .cpu_req   (cpu_req),
        .vector    (vector),
        .vec_taken (vec_taken)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, 16'(reg_rdata), 16'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; src_pulse = '0; wdt_on = 1'b0; gie_set = 1'b0; gie_clr = 1'b0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; ack = 1'b0;
        tick(); tick();
        rst = 1'b0;

        // R10 reset state
        for (int a = 0; a < 5; a++) rd("R10", 3'(a), 8'h00);
        check("R10 req", 16'(cpu_req), 16'h0);
        check("R10 vec_taken", vec_taken, 16'h0000);

        // table walk: R3 R5 R6
        for (int i = 0; i < N_VEC; i++) begin
            logic [14:0] p;
            logic [13:0] m;
            logic        w;
            logic [15:0] ev;
            {p, m, w, ev} = TBL[i];
            wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
            wr(3'd3, m[7:0]); wr(3'd4, {2'b00, m[13:8]});
            wdt_on = w;
            gie_set = 1'b1; tick(); gie_set = 1'b0;
            src_pulse = p; tick(); src_pulse = '0;
            check($sformatf("R5 vector entry %0d", i), vector, ev);
            check($sformatf("R3 req entry %0d", i), 16'(cpu_req), 16'(ev != 16'h0));
        end

        // R8 / R4 / R2: acknowledge the pending rank 7 request (0x001B)
        ack = 1'b1; tick(); ack = 1'b0;
        check("R8 vec_taken", vec_taken, 16'h001B);
        check("R4 ack clears enable", 16'(cpu_req), 16'h0);
        check("R6 vector idle", vector, 16'h0000);
        rd("R2 flag kept", 3'd0, 8'h80);
        gie_set = 1'b1; tick(); gie_set = 1'b0;
        check("R2 retaken", vector, 16'h001B);
        ack = 1'b1; tick(); ack = 1'b0;
        gie_set = 1'b1; tick(); gie_set = 1'b0;
        check("R8 ack without change", vec_taken, 16'h001B);

        // R4 set and clear together -> clear wins
        gie_set = 1'b1; gie_clr = 1'b1; tick(); gie_set = 1'b0; gie_clr = 1'b0;
        check("R4 clear wins", 16'(cpu_req), 16'h0);
        gie_set = 1'b1; tick(); gie_set = 1'b0;
        check("R4 set", 16'(cpu_req), 16'h1);
        gie_clr = 1'b1; tick(); gie_clr = 1'b0;
        check("R4 clear", 16'(cpu_req), 16'h0);

        // R1 set wins over a same-cycle software clear
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00; src_pulse = 15'h0001;
        tick();
        reg_wr = 1'b0; src_pulse = '0;
        rd("R1 set wins", 3'd0, 8'h01);
        src_pulse = 15'h0020; tick(); src_pulse = '0;
        tick(); tick();
        rd("R1 sticky", 3'd0, 8'h21);

        // R9 layout with zero-reading unused bits
        wr(3'd1, 8'hFF); rd("R9 status mid", 3'd1, 8'h0F);
        wr(3'd2, 8'hFF); rd("R9 status high", 3'd2, 8'h07);
        wr(3'd4, 8'hFF); rd("R9 mask high", 3'd4, 8'h3F);
        wr(3'd3, 8'hA5); rd("R9 mask low", 3'd3, 8'hA5);
        wr(3'd6, 8'hFF); rd("R9 unused addr", 3'd6, 8'h00);

        // R7 / R5: only rank 14 pending and enabled, others cleared
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h04);
        gie_set = 1'b1; tick(); gie_set = 1'b0;
        check("R5 lowest rank", vector, 16'h0036);

        // R10 again after reset
        rst = 1'b1; tick(); rst = 1'b0;
        rd("R10 flags", 3'd2, 8'h00);
        check("R10 latch", vec_taken, 16'h0000);
        check("R10 req", 16'(cpu_req), 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule